// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and blanking strobes of a raster display, together with the byte address in frame memory of the line being scanned. Each clock is one horizontal unit of two pixels. The vertical position is kept in half-line units. Every window edge comes from a register that is loaded through a single-cycle write port. A window whose start value is larger than its end value wraps through counter zero. This lets a sync pulse straddle the line or frame origin.

The fetch address starts each frame at a start address, which is derived from a pixel pan offset, a line pitch and a colour-mode code. It then steps by the pitch on each visible line. Pan offsets written by software are held in a shadow copy. They become active only when vertical blanking begins, so a pan never shears a visible frame. A control word can separately enable the two sync outputs and can force the display blank.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter advances by one per clock from 0. The clock after it reaches hperiod+1 (or any larger value), it returns to 0. A line therefore lasts hperiod+2 clocks.
- R2: The vertical counter changes only when a line ends. It then steps by 2, or returns to 0 when the stepped value would be at or above vperiod. A frame therefore lasts (hperiod+2)*vperiod/2 clocks.
- R3: hsync is high while the horizontal count c satisfies hssync <= c < hesync. When hssync > hesync the window wraps, and hsync is high for c >= hssync or c < hesync. vsync follows the same rule with vssync/vesync on the vertical count. An equal start and end gives an empty window.
- R4: blank is high while the horizontal count lies in the window [hsblank, heblank) or the vertical count lies in [vsblank, veblank). Both windows use the wrapping rule of R3.
- R5: In the control word, bits 5:4 enable hsync and bits 1:0 enable vsync. A sync output is enabled when either bit of its pair is set. When both bits of a pair are clear, that sync output stays low.
- R6: Control bit 10 forces blank high, whatever the counters are.
- R7: Each new line whose vertical count is visible updates the line address. If that count equals veblank, the line address loads the active start address. Otherwise the pitch is added to it. The line address holds on every other cycle.
- R8: Writes to the x and y offsets go to shadow registers. When a line begins with vertical count equal to vsblank, the active start becomes (y*pitch + (x << shift)) with bits 4:0 cleared (32-byte alignment).
- R9: The colour-mode code selects the shift in R8: 0 gives 0 (8 bpp), 1 gives 1 (16 bpp), 2 gives 2 (32 bpp). Code 3 acts as code 2. Only bits 1:0 of the written value are kept.
- R10: The write map is as follows. Address 1 is vsblank, 2 is veblank, 4 is vesync, 5 is vssync, 6 is vperiod, 8 is hperiod, 9 is hsblank, 10 is heblank, 11 is hesync and 12 is hssync. Address 16 is pitch, 17 is x offset, 18 is y offset, 19 is colour mode and 20 is control. Writes to addresses 0, 3, 7, 13, 14, 15 and 21 to 31 change no output.
- R11: The synchronous reset clears all registers and counters. It drives hsync and vsync low, blank high and the fetch address to 0.
- R12: A write takes effect from the clock edge that captures it. All outputs are registered and show the counter state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one horizontal unit (two pixels) per cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address (map in R10) |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | Display blank, active high |
| fetch_addr_o | output | 32 | Byte address in frame memory of the current line |

## Verification
The hardest case to reach is a pan written in the middle of a visible frame. The new start must not appear on the next visible line. It must appear only in the frame that follows the next vertical-blank entry, and it must be aligned and scaled by the colour mode. The stimulus writes new offsets and a new colour mode while lines are being scanned. A behavioural model replays the shadow-to-active copy at the line where vertical blanking starts and compares the fetch address on every clock. Sync windows are exercised both wrapping through zero and not wrapping, and pulse widths and periods are counted over whole frames.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    parameter int DW = 32;
    parameter int AW = 5;
    localparam int ALIGN_BITS = 5;

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] slot_t;

    localparam word_t ALIGN_MASK = ~word_t'((1 << ALIGN_BITS) - 1);

    // write-port slots (R10)
    localparam slot_t SL_VSBLANK = 5'd1;
    localparam slot_t SL_VEBLANK = 5'd2;
    localparam slot_t SL_VESYNC  = 5'd4;
    localparam slot_t SL_VSSYNC  = 5'd5;
    localparam slot_t SL_VPERIOD = 5'd6;
    localparam slot_t SL_HPERIOD = 5'd8;
    localparam slot_t SL_HSBLANK = 5'd9;
    localparam slot_t SL_HEBLANK = 5'd10;
    localparam slot_t SL_HESYNC  = 5'd11;
    localparam slot_t SL_HSSYNC  = 5'd12;
    localparam slot_t SL_PITCH   = 5'd16;
    localparam slot_t SL_XOFF    = 5'd17;
    localparam slot_t SL_YOFF    = 5'd18;
    localparam slot_t SL_CMODE   = 5'd19;
    localparam slot_t SL_CTRL    = 5'd20;

    typedef struct packed {
        word_t hperiod;
        word_t hsblank;
        word_t heblank;
        word_t hesync;
        word_t hssync;
        word_t vperiod;
        word_t vsblank;
        word_t veblank;
        word_t vesync;
        word_t vssync;
    } timing_t;

    typedef struct packed {
        logic       blank_force;
        logic [1:0] hs_en;
        logic [1:0] vs_en;
    } ctrl_t;
endpackage

// File: rtl/rtg_window.sv
module rtg_window
    import rtg_pkg::*;
(
    input  word_t count_i,
    input  word_t start_i,
    input  word_t stop_i,
    output logic  active_o
);
    logic straight;

    always_comb begin
        straight = (start_i <= stop_i);
        if (straight) begin
            active_o = (count_i >= start_i) && (count_i < stop_i);
        end else begin
            active_o = (count_i >= start_i) || (count_i < stop_i);
        end
    end
endmodule

// File: rtl/rtg_regbank.sv
module rtg_regbank
    import rtg_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    wr_en_i,
    input  slot_t   wr_addr_i,
    input  word_t   wr_data_i,
    input  logic    xfer_i,
    output timing_t timing_o,
    output word_t   pitch_o,
    output ctrl_t   ctrl_o,
    output word_t   start_o
);
    typedef struct packed {
        timing_t    tim;
        word_t      pitch;
        word_t      xoff;
        word_t      yoff;
        logic [1:0] cmode;
        ctrl_t      ctrl;
        word_t      start;
    } bank_t;

    bank_t      bank_d, bank_q;
    logic [1:0] shift;
    word_t      linear;

    always_comb begin
        bank_d = bank_q;
        shift  = (bank_q.cmode == 2'd3) ? 2'd2 : bank_q.cmode;
        linear = (bank_q.yoff * bank_q.pitch) + (bank_q.xoff << shift);
        if (xfer_i) begin
            bank_d.start = linear & ALIGN_MASK;
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                SL_VSBLANK: bank_d.tim.vsblank = wr_data_i;
                SL_VEBLANK: bank_d.tim.veblank = wr_data_i;
                SL_VESYNC:  bank_d.tim.vesync  = wr_data_i;
                SL_VSSYNC:  bank_d.tim.vssync  = wr_data_i;
                SL_VPERIOD: bank_d.tim.vperiod = wr_data_i;
                SL_HPERIOD: bank_d.tim.hperiod = wr_data_i;
                SL_HSBLANK: bank_d.tim.hsblank = wr_data_i;
                SL_HEBLANK: bank_d.tim.heblank = wr_data_i;
                SL_HESYNC:  bank_d.tim.hesync  = wr_data_i;
                SL_HSSYNC:  bank_d.tim.hssync  = wr_data_i;
                SL_PITCH:   bank_d.pitch       = wr_data_i;
                SL_XOFF:    bank_d.xoff        = wr_data_i;
                SL_YOFF:    bank_d.yoff        = wr_data_i;
                SL_CMODE:   bank_d.cmode       = wr_data_i[1:0];
                SL_CTRL: begin
                    bank_d.ctrl.blank_force = wr_data_i[10];
                    bank_d.ctrl.hs_en       = wr_data_i[5:4];
                    bank_d.ctrl.vs_en       = wr_data_i[1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign timing_o = bank_q.tim;
    assign pitch_o  = bank_q.pitch;
    assign ctrl_o   = bank_q.ctrl;
    assign start_o  = bank_q.start;

    // R8
    start_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(xfer_i) |-> $stable(start_o));

    // R8
    start_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  word_t hperiod_i,
    input  word_t vperiod_i,
    output word_t hcnt_o,
    output word_t vcnt_o,
    output logic  line_end_o,
    output word_t vnext_o
);
    localparam logic [CNT_W-1:0] V_STEP = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
    } cnt_t;

    cnt_t  cnt_d, cnt_q;
    word_t vsum;

    always_comb begin
        cnt_d      = cnt_q;
        hcnt_o     = DW'(cnt_q.h);
        vcnt_o     = DW'(cnt_q.v);
        line_end_o = (hcnt_o >= hperiod_i + 1);
        vsum       = vcnt_o + DW'(V_STEP);
        vnext_o    = (vsum >= vperiod_i) ? '0 : vsum;
        if (line_end_o) begin
            cnt_d.h = '0;
            cnt_d.v = vnext_o[CNT_W-1:0];
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R1
    hcnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        line_end_o |=> (hcnt_o == '0));

    // R2
    vcnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !line_end_o |=> $stable(vcnt_o));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   wr_en_i,
    input  logic [rtg_pkg::AW-1:0] wr_addr_i,
    input  logic [rtg_pkg::DW-1:0] wr_data_i,
    output logic                   hsync_o,
    output logic                   vsync_o,
    output logic                   blank_o,
    output logic [rtg_pkg::DW-1:0] fetch_addr_o
);
    typedef struct packed {
        word_t line_addr;
        word_t addr;
        logic  hs;
        logic  vs;
        logic  blank;
    } out_t;

    timing_t tim;
    ctrl_t   ctrl;
    word_t   pitch, start;
    word_t   hcnt, vcnt, vnext;
    logic    line_end, xfer;
    logic    hs_win, vs_win, hb_win, vb_win, vn_blank;
    out_t    st_d, st_q;

    assign xfer = line_end && (vnext == tim.vsblank);

    rtg_regbank u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .xfer_i    (xfer),
        .timing_o  (tim),
        .pitch_o   (pitch),
        .ctrl_o    (ctrl),
        .start_o   (start)
    );

    rtg_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hperiod_i  (tim.hperiod),
        .vperiod_i  (tim.vperiod),
        .hcnt_o     (hcnt),
        .vcnt_o     (vcnt),
        .line_end_o (line_end),
        .vnext_o    (vnext)
    );

    rtg_window u_hs_win (.count_i(hcnt),  .start_i(tim.hssync),  .stop_i(tim.hesync),  .active_o(hs_win));
    rtg_window u_vs_win (.count_i(vcnt),  .start_i(tim.vssync),  .stop_i(tim.vesync),  .active_o(vs_win));
    rtg_window u_hb_win (.count_i(hcnt),  .start_i(tim.hsblank), .stop_i(tim.heblank), .active_o(hb_win));
    rtg_window u_vb_win (.count_i(vcnt),  .start_i(tim.vsblank), .stop_i(tim.veblank), .active_o(vb_win));
    rtg_window u_vn_win (.count_i(vnext), .start_i(tim.vsblank), .stop_i(tim.veblank), .active_o(vn_blank));

    always_comb begin
        st_d       = st_q;
        st_d.hs    = (|ctrl.hs_en) && hs_win;
        st_d.vs    = (|ctrl.vs_en) && vs_win;
        st_d.blank = ctrl.blank_force || hb_win || vb_win;
        st_d.addr  = st_q.line_addr;
        if (line_end && !vn_blank) begin
            st_d.line_addr = (vnext == tim.veblank) ? start : st_q.line_addr + pitch;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q       <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_o      = st_q.hs;
    assign vsync_o      = st_q.vs;
    assign blank_o      = st_q.blank;
    assign fetch_addr_o = st_q.addr;

    // R5
    hsync_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(|ctrl.hs_en) |-> !hsync_o);

    // R5
    vsync_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(|ctrl.vs_en) |-> !vsync_o);

    // R6
    force_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(ctrl.blank_force) |-> blank_o);

    // R7
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(line_end) |-> $stable(st_q.line_addr));
endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, blank;
    logic [31:0] fetch_addr;

    always #5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .hsync_o      (hsync),
        .vsync_o      (vsync),
        .blank_o      (blank),
        .fetch_addr_o (fetch_addr)
    );

    int    checks = 0;
    int    failures = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R11 reset";

    // behavioural reference model
    int unsigned m_reg [0:31];
    int unsigned mh, mv, mline, mstart;
    bit          e_hs, e_vs, e_bl;
    int unsigned e_ad;

    function automatic bit inwin(int unsigned c, int unsigned s, int unsigned e);
        if (s <= e) return (c >= s) && (c < e);
        return (c >= s) || (c < e);
    endfunction

    function automatic bit mapped(int unsigned a);
        return a inside {1, 2, 4, 5, 6, 8, 9, 10, 11, 12, 16, 17, 18, 19, 20};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0; mline = 0; mstart = 0;
            for (int i = 0; i < 32; i++) m_reg[i] = 0;
            e_hs = 0; e_vs = 0; e_bl = 1; e_ad = 0;   // R11
        end else begin
            automatic int unsigned ctl = m_reg[20];
            automatic int unsigned vn;
            automatic int unsigned sh;
            // outputs show this cycle's position one clock later (R12)
            e_hs = (ctl[5:4] != 0) && inwin(mh, m_reg[12], m_reg[11]);
            e_vs = (ctl[1:0] != 0) && inwin(mv, m_reg[5], m_reg[4]);
            e_bl = ctl[10] || inwin(mh, m_reg[9], m_reg[10]) || inwin(mv, m_reg[1], m_reg[2]);
            e_ad = mline;
            if (mh >= m_reg[8] + 1) begin            // R1
                mh = 0;
                vn = (mv + 2 >= m_reg[6]) ? 0 : mv + 2;  // R2
                if (!inwin(vn, m_reg[1], m_reg[2]))  // R7
                    mline = (vn == m_reg[2]) ? mstart : mline + m_reg[16];
                if (vn == m_reg[1]) begin            // R8, R9
                    sh = (m_reg[19][1:0] == 2'd3) ? 2 : int'(m_reg[19][1:0]);
                    mstart = (m_reg[18] * m_reg[16] + (m_reg[17] << sh)) & 32'hFFFF_FFE0;
                end
                mv = vn;
            end else begin
                mh = mh + 1;
            end
            if (wr_en && mapped(int'(wr_addr))) m_reg[wr_addr] = wr_data;  // R10, R12
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (hsync !== e_hs) begin
                failures++;
                $display("FAIL R3 R5 hsync (%s): actual=%0b expected=%0b t=%0t", phase, hsync, e_hs, $time);
            end
            checks++;
            if (vsync !== e_vs) begin
                failures++;
                $display("FAIL R3 R5 vsync (%s): actual=%0b expected=%0b t=%0t", phase, vsync, e_vs, $time);
            end
            checks++;
            if (blank !== e_bl) begin
                failures++;
                $display("FAIL R4 R6 blank (%s): actual=%0b expected=%0b t=%0t", phase, blank, e_bl, $time);
            end
            checks++;
            if (fetch_addr !== e_ad) begin
                failures++;
                $display("FAIL R7 R8 fetch_addr (%s): actual=%0h expected=%0h t=%0t", phase, fetch_addr, e_ad, $time);
            end
        end
    end

    task automatic wr(input int unsigned a, input int unsigned d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // counts high cycles over one full frame (126 clocks)
    task automatic count_frame(input int exp_hs, input int exp_vs, input int exp_vis, input string tag);
        int nh = 0, nv = 0, nvis = 0;
        for (int i = 0; i < 126; i++) begin
            @(negedge clk);
            nh += int'(hsync); nv += int'(vsync); nvis += int'(!blank);
        end
        expect_int({tag, " R3 hsync cycles/frame"}, nh, exp_hs);
        expect_int({tag, " R3 vsync cycles/frame"}, nv, exp_vs);
        expect_int({tag, " R4 visible cycles/frame"}, nvis, exp_vis);
    endtask

    // distance between rising edges of a strobe
    task automatic period_of(input bit use_v, input int exp, input string tag);
        int n = 0;
        bit prev;
        bit cur;
        prev = use_v ? vsync : hsync;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cur = use_v ? vsync : hsync;
            if (cur && !prev) break;
            prev = cur;
        end
        prev = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            cur = use_v ? vsync : hsync;
            if (cur && !prev) break;
            prev = cur;
        end
        expect_int(tag, n, exp);
    endtask

    task automatic program_mode();
        wr(8, 12); wr(12, 13); wr(11, 1); wr(9, 11); wr(10, 3);   // horizontal
        wr(6, 18); wr(5, 16); wr(4, 2); wr(2, 6); wr(1, 14);     // vertical
        wr(16, 64); wr(19, 1); wr(20, 32'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_on = 1'b1;                     // R11: reset values checked here
        idle(2);
        rst = 1'b0;
        phase = "R11 after reset";
        idle(5);
        phase = "R10 R12 programming";
        program_mode();
        idle(300);
        phase = "R1 R2 periods";
        period_of(1'b0, 14, "R1 line period");
        period_of(1'b1, 126, "R2 frame period");
        count_frame(18, 28, 32, "wrapping sync");
        phase = "R8 R9 mid-frame pan";
        idle(40);
        wr(17, 20); wr(18, 3);             // 3*64 + 40 = 232 -> 224
        idle(300);
        phase = "R9 colour mode 32bpp";
        wr(19, 2); wr(17, 9);              // 192 + 36 = 228 -> 224
        idle(260);
        wr(19, 3); wr(17, 8);              // code 3 as 2: 192 + 32 = 224
        idle(260);
        phase = "R10 unused slots";
        wr(0, 32'h5); wr(3, 32'h7); wr(7, 32'h9); wr(13, 1);
        wr(14, 2); wr(15, 3); wr(25, 32'hFFFF); wr(31, 0);
        idle(200);
        count_frame(18, 28, 32, "R10 after unused");
        phase = "R5 vsync disabled";
        wr(20, 32'h30);
        idle(150);
        count_frame(18, 0, 32, "R5 vs off");
        phase = "R5 hsync disabled";
        wr(20, 32'h02);
        idle(150);
        count_frame(0, 28, 32, "R5 hs off");
        phase = "R6 forced blank";
        wr(20, 32'h433);
        idle(150);
        count_frame(18, 28, 0, "R6 forced");
        phase = "R3 non-wrapping sync";
        wr(20, 32'h11);
        wr(12, 4); wr(11, 6);
        idle(200);
        count_frame(18, 28, 32, "R3 straight");
        phase = "R2 shorter frame";
        wr(6, 14); wr(5, 12); wr(1, 10);
        idle(300);
        phase = "R7 pitch change";
        wr(16, 128);
        idle(300);
        chk_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule